// File: doc/BRIEF.md
# GPIO Port Controller with Per-Pin Write Lock

This block controls one port of general-purpose pins through a small synchronous register bus. Software sets each pin's direction and output level, picks a drive-strength class and turns the pull-up on or off per pin. The block turns those settings into pad-control signals: output enable, output value, drive select and pull-up enable. Reads of the data address return the pin levels after a two-flop synchronizer, so an asynchronous pad can be sampled safely.

A separate parameter word holds one lock bit per pin. While a pin's lock bit is set, writes to that pin's bit in the direction register or the output register are dropped without notice. Other pins in the same write still update. The lock bits stay writable at all times, so a pin can be unlocked later. The bus has no handshake. A write takes effect at the clock edge where `bus_wr_en` is high. Read data is registered: it shows the word at the address that was presented at the previous clock edge.

Top module: `gpio_lock_port`

## Requirements
- R1: After a synchronous active-high reset, `pad_oe`, `pad_out`, `pad_drv_hi` and `bus_rdata` are all 0 and `pad_pu_en` is all 1. At reset all lock bits are 0.
- R2: A write to address 0x0 (direction register, 1 = pin driven) updates every unlocked bit. The new value appears on `pad_oe` after that edge. A read of 0x0 returns the stored bits in [7:0] and zeros above them.
- R3: A write to address 0x1 updates the output register for every unlocked bit. The new value appears on `pad_out` after that edge.
- R4: Address 0x2 is the parameter word, laid out as lock [23:16], drive select [15:8] and pull-up disable [7:0]. A read returns the stored fields, and bits [31:24] read as 0 whatever was written to them.
- R5: When a pin's lock bit is 1, a write to address 0x0 or 0x1 leaves that pin's bit unchanged. In the same write, the bits of unlocked pins take the new value.
- R6: `pad_drv_hi[i]` equals drive-select bit i: 0 selects the 2 mA class and 1 selects the 4 mA class.
- R7: `pad_pu_en[i]` is the inverse of pull-up-disable bit i.
- R8: A read of address 0x1 returns the pin inputs through a two-stage synchronizer. Suppose a pin change is applied between edges and the read address is already held. The read data then still shows the old level after the first and second edges and shows the new level after the third edge.
- R9: Writes to addresses other than 0x0, 0x1 and 0x2 change no register or pad output. Reads of those addresses return 0.
- R10: The lock bits can always be written, including cleared. Once a lock bit is cleared, the matching direction and output bits accept writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wr_en | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_drv_hi | output | 8 | Per-pin high drive-strength select |
| pad_pu_en | output | 8 | Per-pin pull-up enable |

## Verification
A wrong lock mask, or a register that drops or corrupts a bit, shows up on `pad_oe`, `pad_out`, `pad_drv_hi` or `pad_pu_en` right after the edge that performed the write. The bench compares all four pad outputs to its model after every write, so such an error is reported at the write that caused it. A synchronizer of the wrong depth shows up as a data-address read that turns over one edge too early or too late, which the directed edge-by-edge read exposes. Decode faults are covered too: an unmapped write that reaches a real register changes a pad output at the next check, and a nonzero reserved field appears in the very next read.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  // Word addresses of the register bus
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_DATA  = 1;
  localparam int unsigned ADDR_PARAM = 2;

  // Field slots of the parameter word, in units of the pin count
  localparam int unsigned SLOT_PUD  = 0;
  localparam int unsigned SLOT_DRV  = 1;
  localparam int unsigned SLOT_LOCK = 2;
  localparam int unsigned NUM_SLOTS = 3;
endpackage

// File: rtl/gpio_lock_masked_reg.sv
module gpio_lock_masked_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lock,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= 1'b0;
      else if (wr_sel && !lock[i])
        q[i] <= wdata[i];
    end
  end

  // R5: locked bits never change
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((q ^ $past(q)) & $past(lock)) == '0));

  // R2/R3: unlocked bits take the written value
  p_unlocked_take_r2: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> ((q & ~$past(lock)) == ($past(wdata) & ~$past(lock))));

  // R9: no write, no change
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(q));
endmodule

// File: rtl/gpio_lock_param_reg.sv
module gpio_lock_param_reg
  import gpio_lock_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_sel,
  input  logic [DW-1:0] wdata,
  output logic [N-1:0]  lock,
  output logic [N-1:0]  drv_hi,
  output logic [N-1:0]  pud
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock   <= '0;
      drv_hi <= '0;
      pud    <= '0;
    end else if (wr_sel) begin
      lock   <= wdata[SLOT_LOCK*N +: N];
      drv_hi <= wdata[SLOT_DRV*N  +: N];
      pud    <= wdata[SLOT_PUD*N  +: N];
    end
  end

  // R10: the lock field is always writable
  p_lock_writable_r10: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> (lock == $past(wdata[SLOT_LOCK*N +: N])));
endmodule

// File: rtl/gpio_lock_sync.sv
module gpio_lock_sync #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_sync
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst)
        chain_q <= '0;
      else
        chain_q <= {chain_q[STAGES-2:0], pin_in[i]};
    end
    assign pin_sync[i] = chain_q[STAGES-1];
  end

  if (STAGES == 2) begin : g_chk
    logic [1:0] primed_q;
    always_ff @(posedge clk) begin
      if (rst)
        primed_q <= '0;
      else if (primed_q != 2'd2)
        primed_q <= primed_q + 2'd1;
    end
    // R8: synchronized value lags the pin by two edges
    p_sync_lag_r8: assert property (@(posedge clk) disable iff (rst)
      (primed_q == 2'd2) |-> (pin_sync == $past(pin_in, 2)));
  end
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
  import gpio_lock_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr_en,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pad_oe,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_drv_hi,
  output logic [N-1:0]  pad_pu_en
);
  localparam logic [AW-1:0] A_CTRL  = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] A_DATA  = AW'(ADDR_DATA);
  localparam logic [AW-1:0] A_PARAM = AW'(ADDR_PARAM);
  localparam int unsigned   USED    = NUM_SLOTS * N;

  logic          sel_ctrl, sel_data, sel_param;
  logic [N-1:0]  lock, pud, pin_sync;
  logic [DW-1:0] rd_next;

  assign sel_ctrl  = bus_wr_en && (bus_addr == A_CTRL);
  assign sel_data  = bus_wr_en && (bus_addr == A_DATA);
  assign sel_param = bus_wr_en && (bus_addr == A_PARAM);

  gpio_lock_masked_reg #(.W(N)) u_ctrl (
    .clk(clk), .rst(rst), .wr_sel(sel_ctrl), .wdata(bus_wdata[N-1:0]),
    .lock(lock), .q(pad_oe)
  );

  gpio_lock_masked_reg #(.W(N)) u_data (
    .clk(clk), .rst(rst), .wr_sel(sel_data), .wdata(bus_wdata[N-1:0]),
    .lock(lock), .q(pad_out)
  );

  gpio_lock_param_reg #(.N(N), .DW(DW)) u_param (
    .clk(clk), .rst(rst), .wr_sel(sel_param), .wdata(bus_wdata),
    .lock(lock), .drv_hi(pad_drv_hi), .pud(pud)
  );

  gpio_lock_sync #(.N(N), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  assign pad_pu_en = ~pud;

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_CTRL:  rd_next[N-1:0] = pad_oe;
      A_DATA:  rd_next[N-1:0] = pin_sync;
      A_PARAM: rd_next[USED-1:0] = {lock, pad_drv_hi, pud};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else
      bus_rdata <= rd_next;
  end

  // R4: reserved bits of the parameter word read as zero
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == A_PARAM) |-> ((bus_rdata >> USED) == '0));

  // R9: unmapped writes touch nothing
  p_unmapped_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr != A_CTRL && bus_addr != A_DATA && bus_addr != A_PARAM)
    |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_drv_hi) && $stable(pad_pu_en)));

  // R7: pull-up enable only moves on a parameter write
  p_pu_moves_on_write_r7: assert property (@(posedge clk) disable iff (rst)
    !sel_param |=> $stable(pad_pu_en));
endmodule

// File: tb/gpio_lock_port_tb.sv
module gpio_lock_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pad_oe, pad_out, pad_drv_hi, pad_pu_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model
  logic [7:0] m_ctrl = '0, m_data = '0, m_lock = '0, m_drv = '0, m_pud = '0;

  always #4 clk = ~clk;

  gpio_lock_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_drv_hi(pad_drv_hi),
    .pad_pu_en(pad_pu_en)
  );

  function automatic logic [7:0] merge(logic [7:0] old, logic [7:0] wd, logic [7:0] lk);
    return (old & lk) | (wd & ~lk);
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a, logic [7:0] pins);
    case (a)
      4'd0:    return {24'd0, m_ctrl};
      4'd1:    return {24'd0, pins};
      4'd2:    return {8'd0, m_lock, m_drv, m_pud};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_write(logic [3:0] a, logic [31:0] d);
    case (a)
      4'd0: m_ctrl = merge(m_ctrl, d[7:0], m_lock);
      4'd1: m_data = merge(m_data, d[7:0], m_lock);
      4'd2: begin m_lock = d[23:16]; m_drv = d[15:8]; m_pud = d[7:0]; end
      default: ;
    endcase
  endtask

  task automatic check_pads(string req);
    chk({req, " pad_oe"},     {24'd0, pad_oe},     {24'd0, m_ctrl});
    chk({req, " pad_out"},    {24'd0, pad_out},    {24'd0, m_data});
    chk({req, " pad_drv_hi"}, {24'd0, pad_drv_hi}, {24'd0, m_drv});
    chk({req, " pad_pu_en"},  {24'd0, pad_pu_en},  {24'd0, ~m_pud});
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wr_en = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check_pads("R1");
    chk("R1 rdata", bus_rdata, 32'd0);
    rst = 1'b0;

    // R2 / R3: basic writes
    wr(4'd0, 32'h0000_00A5);
    check_pads("R2");
    rd(4'd0, v); chk("R2 read ctrl", v, 32'h0000_00A5);
    wr(4'd1, 32'hFFFF_FF3C);
    check_pads("R3");

    // R4 / R6 / R7: parameter word with reserved bits set
    wr(4'd2, 32'hFF0F_33C3);
    rd(4'd2, v); chk("R4 read param", v, 32'h000F_33C3);
    chk("R6 drive select", {24'd0, pad_drv_hi}, 32'h33);
    chk("R7 pull-up enable", {24'd0, pad_pu_en}, 32'h3C);

    // R5: lock low nibble, mixed write
    wr(4'd0, 32'h0000_005A);
    chk("R5 ctrl partial", {24'd0, pad_oe}, 32'h55);
    wr(4'd1, 32'h0000_00FF);
    chk("R5 data partial", {24'd0, pad_out}, 32'hFC);
    check_pads("R5");

    // R10: clear locks, writes accepted again
    wr(4'd2, 32'h0000_0000);
    wr(4'd0, 32'h0000_005A);
    chk("R10 unlocked ctrl", {24'd0, pad_oe}, 32'h5A);
    check_pads("R10");

    // R9: unmapped addresses
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    check_pads("R9");
    rd(4'd3, v); chk("R9 read unmapped", v, 32'd0);

    // R8: synchronizer latency, edge by edge
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    bus_addr = 4'd1; bus_wr_en = 1'b0; pin_in = 8'h96;
    @(negedge clk); chk("R8 edge1 old", bus_rdata, 32'h00);
    @(negedge clk); chk("R8 edge2 old", bus_rdata, 32'h00);
    @(negedge clk); chk("R8 edge3 new", bus_rdata, 32'h96);

    // random mix against the model
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [3:0] a;
      logic [31:0] d;
      op = $urandom_range(0, 5);
      d  = $urandom;
      case (op)
        0: a = 4'd0;
        1: a = 4'd1;
        2: a = 4'd2;
        3: a = 4'($urandom_range(3, 15));
        default: a = 4'($urandom_range(0, 3));
      endcase
      if (op == 2 && ($urandom_range(0, 1) == 0)) d[23:16] = 8'h00;
      if (op <= 3) begin
        wr(a, d);
        check_pads(op == 3 ? "R9" : (op == 2 ? "R4" : "R5"));
      end else if (a == 4'd1) begin
        logic [7:0] p;
        p = 8'($urandom);
        @(negedge clk); pin_in = p;
        repeat (3) @(negedge clk);
        rd(4'd1, v); chk("R8 random pins", v, exp_read(4'd1, p));
      end else begin
        rd(a, v); chk(a == 4'd2 ? "R4 random read" : "R2 random read", v, exp_read(a, pin_in));
      end
    end
    finish_run();
  end
endmodule